// File: doc/BRIEF.md
# DRAM Command and Address Decoder

This block is the device-side front end of a DDR3-style memory. At every rising clock edge it samples chip select, the three active-low command strobes, the bank address and the address bus, and turns them into one registered command with its fields broken out: target bank, row, column, auto-precharge flag, all-bank flag, effective burst length and target mode register. Address bits change meaning with the command. Bit 10 means auto-precharge on a read or write, and all-bank on a precharge. Bit 12 selects a burst chop on the fly when the mode setting allows it. On a mode-register load, the bank bits name a register.

The block keeps the four mode registers and a per-bank open/closed map. It flags a read or write that targets a closed bank. It follows clock-enable through precharge power-down, active power-down and self-refresh. It gates the on-die-termination request with the termination-enable mode bit. All outputs are registered and appear one cycle after the edge that sampled the inputs.

Top module: `dram_cmd_decoder`

## Requirements
- R1: When `cs_ni` is sampled high, `cmd_o` reads NOP (0) and no bank or mode-register state changes, whatever the strobes carry.
- R2: With `cs_ni` low, `{ras_ni,cas_ni,we_ni}` decodes as 011 activate (`cmd_o`=1), 101 read (2), 100 write (3), 010 precharge (4), 001 refresh (5), 000 mode load (6), and 111 or 110 as NOP (0). Fields a command does not use read zero.
- R3: An activate marks bank `ba_i` open in `bank_open_o` (bit n = bank n) and outputs `bank_o`=`ba_i` and `row_o`=`addr_i`.
- R4: On a precharge, with `addr_i[10]` low only bank `ba_i` closes and `all_bank_o`=0. With `addr_i[10]` high every bank closes, `all_bank_o`=1 and `bank_o`=0.
- R5: On a read or write, `col_o`=`addr_i[9:0]`, `bank_o`=`ba_i` and `auto_pre_o`=`addr_i[10]`. When `addr_i[10]` is high, the bank is closed after the command.
- R6: When mode register 0 bits [1:0] are 01 (on-the-fly), a read or write gives `burst_len_o`=8 if `addr_i[12]` is high and 4 if it is low.
- R7: When mode register 0 bits [1:0] are 10, a read or write gives `burst_len_o`=4. For 00 or 11 it gives 8. In both cases `addr_i[12]` has no effect.
- R8: A mode load with `ba_i[2]`=0 writes `addr_i` into register `ba_i[1:0]`, seen at `mr_flat_o[16*k +: 16]`, and outputs `mr_sel_o`=`ba_i[1:0]`. With `ba_i[2]`=1, no register changes.
- R9: `err_o` pulses with a read or write whose bank was closed before that command.
- R10: `pwr_state_o` is 0 when active, 1 in precharge power-down, 2 in active power-down and 3 in self-refresh. When `cke_i` is sampled low while active, the block enters 3 if the command is a refresh and all banks are idle, 2 if any bank is open, and 1 otherwise. When `cke_i` is sampled high in a low-power state, it returns to 0. Commands are NOP while `cke_i` is low or the block is not active.
- R11: `odt_en_o` follows the sampled `odt_i` only while mode register 1 bit 2 is set, and is 0 otherwise.
- R12: Asserting `rst_ni` low clears the mode registers, closes all banks, sets the power state to 0 and forces every output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge samples |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cke_i | input | 1 | Clock enable |
| cs_ni | input | 1 | Chip select, active low |
| ras_ni | input | 1 | Row strobe, active low |
| cas_ni | input | 1 | Column strobe, active low |
| we_ni | input | 1 | Write enable, active low |
| ba_i | input | 3 | Bank address |
| addr_i | input | 16 | Address bus |
| odt_i | input | 1 | Termination request |
| cmd_o | output | 3 | Decoded command code |
| bank_o | output | 3 | Target bank |
| row_o | output | 16 | Row address on activate |
| col_o | output | 10 | Column address on read/write |
| auto_pre_o | output | 1 | Auto-precharge flag |
| all_bank_o | output | 1 | Precharge applies to all banks |
| burst_len_o | output | 4 | Effective burst length (4 or 8) |
| mr_sel_o | output | 2 | Mode register targeted by a load |
| err_o | output | 1 | Access to a closed bank |
| bank_open_o | output | 8 | Open map, bit per bank |
| pwr_state_o | output | 2 | Power state |
| odt_en_o | output | 1 | Effective termination enable |
| mr_flat_o | output | 64 | Mode registers 3..0 packed |

## Verification
The bench targets the places where address bits change roles. It sends a precharge with bit 10 high to catch a design that closes only one bank. It sends reads with bit 12 low under a fixed-length setting to catch a design that chops the burst anyway. It sends a mode load with the top bank bit set to catch a design that overwrites a register. Self-refresh entry is tried with banks open and with banks idle, so that a design taking open rows into self-refresh shows up in `pwr_state_o`. The termination request is toggled with the mode bit set and cleared. A chip-select-high cycle carrying an activate code must leave the bank map untouched. A read to a closed bank must raise `err_o`.

// File: rtl/dcd_pkg.sv
package dcd_pkg;
  typedef enum logic [2:0] {
    CMD_NOP = 3'd0, CMD_ACT = 3'd1, CMD_RD = 3'd2, CMD_WR = 3'd3,
    CMD_PRE = 3'd4, CMD_REF = 3'd5, CMD_MRS = 3'd6
  } cmd_e;

  typedef enum logic [1:0] {
    PWR_ON = 2'd0, PWR_PPD = 2'd1, PWR_APD = 2'd2, PWR_SR = 2'd3
  } pwr_e;

  localparam int AP_BIT    = 10;  // auto-precharge / all-bank
  localparam int BC_BIT    = 12;  // on-the-fly chop select
  localparam int TERM_BIT  = 2;   // MR1 termination enable
  localparam int BL_LEN_W  = 4;
endpackage

// File: rtl/dcd_cmd_decode.sv
module dcd_cmd_decode
  import dcd_pkg::*;
(
  input  logic cs_ni,
  input  logic ras_ni,
  input  logic cas_ni,
  input  logic we_ni,
  output cmd_e cmd_o
);
  always_comb begin
    cmd_o = CMD_NOP;
    if (!cs_ni) begin
      unique case ({ras_ni, cas_ni, we_ni})
        3'b011:  cmd_o = CMD_ACT;
        3'b101:  cmd_o = CMD_RD;
        3'b100:  cmd_o = CMD_WR;
        3'b010:  cmd_o = CMD_PRE;
        3'b001:  cmd_o = CMD_REF;
        3'b000:  cmd_o = CMD_MRS;
        default: cmd_o = CMD_NOP;
      endcase
    end
  end
endmodule

// File: rtl/dcd_power_fsm.sv
module dcd_power_fsm
  import dcd_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cke_i,
  input  logic raw_ref_i,
  input  logic any_open_i,
  output pwr_e state_o,
  output logic cmd_en_o
);
  pwr_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (state_q == PWR_ON) begin
      if (!cke_i) begin
        if (raw_ref_i && !any_open_i) state_d = PWR_SR;
        else if (any_open_i)          state_d = PWR_APD;
        else                          state_d = PWR_PPD;
      end
    end else if (cke_i) begin
      state_d = PWR_ON;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= PWR_ON;
    else         state_q <= state_d;
  end

  assign state_o  = state_q;
  assign cmd_en_o = (state_q == PWR_ON) && cke_i;

  // staying in a low-power state needs cke held low
  assert_hold_low_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != PWR_ON && $past(state_q) != PWR_ON) |-> $past(!cke_i));

  // self-refresh is only entered with every bank idle
  assert_sr_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(state_q == PWR_SR) |-> $past(!any_open_i));
endmodule

// File: rtl/dcd_bank_tracker.sv
module dcd_bank_tracker
  import dcd_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  localparam int BA_W = $clog2(NUM_BANKS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  cmd_e                 cmd_i,
  input  logic [BA_W-1:0]      ba_i,
  input  logic                 ap_i,
  output logic [NUM_BANKS-1:0] open_o,
  output logic                 hit_o
);
  logic [NUM_BANKS-1:0] open_q;

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    logic sel;
    assign sel = (ba_i == BA_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        open_q[g] <= 1'b0;
      end else begin
        unique case (cmd_i)
          CMD_ACT: if (sel) open_q[g] <= 1'b1;
          CMD_PRE: if (ap_i || sel) open_q[g] <= 1'b0;
          CMD_RD, CMD_WR: if (ap_i && sel) open_q[g] <= 1'b0;
          default: ;
        endcase
      end
    end
  end

  assign open_o = open_q;
  assign hit_o  = open_q[ba_i];

  assert_pre_all_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == CMD_PRE && ap_i) |=> (open_q == '0));

  assert_act_open_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == CMD_ACT) |=> open_q[$past(ba_i)]);
endmodule

// File: rtl/dcd_mode_regs.sv
module dcd_mode_regs #(
  parameter int NUM_MR = 4,
  parameter int MR_W   = 16,
  parameter int BA_W   = 3,
  localparam int SEL_W = $clog2(NUM_MR)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   we_i,
  input  logic [BA_W-1:0]        ba_i,
  input  logic [MR_W-1:0]        data_i,
  output logic [NUM_MR*MR_W-1:0] mr_flat_o
);
  logic wr_ok;
  // bank bits above the select field must be zero
  assign wr_ok = we_i && (ba_i[BA_W-1:SEL_W] == '0);

  for (genvar g = 0; g < NUM_MR; g++) begin : g_mr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  mr_flat_o[g*MR_W +: MR_W] <= '0;
      else if (wr_ok && ba_i[SEL_W-1:0] == SEL_W'(g)) mr_flat_o[g*MR_W +: MR_W] <= data_i;
    end
  end

  assert_mr_drop_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && ba_i[BA_W-1:SEL_W] != '0) |=> $stable(mr_flat_o));
endmodule

// File: rtl/dram_cmd_decoder.sv
module dram_cmd_decoder
  import dcd_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int ADDR_W    = 16,
  parameter int COL_W     = 10,
  parameter int NUM_MR    = 4,
  localparam int BA_W     = $clog2(NUM_BANKS),
  localparam int SEL_W    = $clog2(NUM_MR)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     cke_i,
  input  logic                     cs_ni,
  input  logic                     ras_ni,
  input  logic                     cas_ni,
  input  logic                     we_ni,
  input  logic [BA_W-1:0]          ba_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic                     odt_i,
  output logic [2:0]               cmd_o,
  output logic [BA_W-1:0]          bank_o,
  output logic [ADDR_W-1:0]        row_o,
  output logic [COL_W-1:0]         col_o,
  output logic                     auto_pre_o,
  output logic                     all_bank_o,
  output logic [BL_LEN_W-1:0]      burst_len_o,
  output logic [SEL_W-1:0]         mr_sel_o,
  output logic                     err_o,
  output logic [NUM_BANKS-1:0]     bank_open_o,
  output logic [1:0]               pwr_state_o,
  output logic                     odt_en_o,
  output logic [NUM_MR*ADDR_W-1:0] mr_flat_o
);
  cmd_e raw_cmd, cmd;
  pwr_e pwr;
  logic cmd_en, any_open, hit;
  logic [BL_LEN_W-1:0] bl_d;
  logic [ADDR_W-1:0] mr0, mr1;

  dcd_cmd_decode i_decode (
    .cs_ni(cs_ni), .ras_ni(ras_ni), .cas_ni(cas_ni), .we_ni(we_ni), .cmd_o(raw_cmd)
  );

  assign any_open = |bank_open_o;

  dcd_power_fsm i_power (
    .clk_i(clk_i), .rst_ni(rst_ni), .cke_i(cke_i),
    .raw_ref_i(raw_cmd == CMD_REF), .any_open_i(any_open),
    .state_o(pwr), .cmd_en_o(cmd_en)
  );

  assign cmd = cmd_en ? raw_cmd : CMD_NOP;

  dcd_bank_tracker #(.NUM_BANKS(NUM_BANKS)) i_banks (
    .clk_i(clk_i), .rst_ni(rst_ni), .cmd_i(cmd), .ba_i(ba_i),
    .ap_i(addr_i[AP_BIT]), .open_o(bank_open_o), .hit_o(hit)
  );

  dcd_mode_regs #(.NUM_MR(NUM_MR), .MR_W(ADDR_W), .BA_W(BA_W)) i_mregs (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(cmd == CMD_MRS), .ba_i(ba_i),
    .data_i(addr_i), .mr_flat_o(mr_flat_o)
  );

  assign mr0 = mr_flat_o[0 +: ADDR_W];
  assign mr1 = mr_flat_o[ADDR_W +: ADDR_W];
  assign pwr_state_o = pwr;

  always_comb begin
    unique case (mr0[1:0])
      2'b01:   bl_d = addr_i[BC_BIT] ? BL_LEN_W'(8) : BL_LEN_W'(4);
      2'b10:   bl_d = BL_LEN_W'(4);
      default: bl_d = BL_LEN_W'(8);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_o       <= CMD_NOP;
      bank_o      <= '0;
      row_o       <= '0;
      col_o       <= '0;
      auto_pre_o  <= 1'b0;
      all_bank_o  <= 1'b0;
      burst_len_o <= '0;
      mr_sel_o    <= '0;
      err_o       <= 1'b0;
      odt_en_o    <= 1'b0;
    end else begin
      cmd_o       <= cmd;
      bank_o      <= '0;
      row_o       <= '0;
      col_o       <= '0;
      auto_pre_o  <= 1'b0;
      all_bank_o  <= 1'b0;
      burst_len_o <= '0;
      mr_sel_o    <= '0;
      err_o       <= 1'b0;
      odt_en_o    <= odt_i && mr1[TERM_BIT];
      unique case (cmd)
        CMD_ACT: begin
          bank_o <= ba_i;
          row_o  <= addr_i;
        end
        CMD_RD, CMD_WR: begin
          bank_o      <= ba_i;
          col_o       <= addr_i[COL_W-1:0];
          auto_pre_o  <= addr_i[AP_BIT];
          burst_len_o <= bl_d;
          err_o       <= !hit;
        end
        CMD_PRE: begin
          all_bank_o <= addr_i[AP_BIT];
          bank_o     <= addr_i[AP_BIT] ? '0 : ba_i;
        end
        CMD_MRS: mr_sel_o <= ba_i[SEL_W-1:0];
        default: ;
      endcase
    end
  end

  assert_cs_mask_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o != CMD_NOP) |-> $past(!cs_ni));

  assert_err_rw_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (cmd_o == CMD_RD || cmd_o == CMD_WR));

  assert_odt_gate_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    odt_en_o |-> $past(odt_i));

  assert_burst_len_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == CMD_RD || cmd_o == CMD_WR) |-> (burst_len_o == 4 || burst_len_o == 8));
endmodule

// File: tb/test_dram_cmd_decoder.sv
`timescale 1ns/1ps
module test_dram_cmd_decoder;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic cke_i = 1'b1, cs_ni = 1'b1, ras_ni = 1'b1, cas_ni = 1'b1, we_ni = 1'b1, odt_i = 1'b0;
  logic [2:0] ba_i = '0;
  logic [15:0] addr_i = '0;
  logic [2:0] cmd_o, bank_o;
  logic [15:0] row_o;
  logic [9:0] col_o;
  logic auto_pre_o, all_bank_o, err_o, odt_en_o;
  logic [3:0] burst_len_o;
  logic [1:0] mr_sel_o, pwr_state_o;
  logic [7:0] bank_open_o;
  logic [63:0] mr_flat_o;

  always #2.5 clk = ~clk;

  dram_cmd_decoder i_dram_cmd_decoder (
    .clk_i(clk), .rst_ni(rst_ni), .cke_i(cke_i), .cs_ni(cs_ni), .ras_ni(ras_ni),
    .cas_ni(cas_ni), .we_ni(we_ni), .ba_i(ba_i), .addr_i(addr_i), .odt_i(odt_i),
    .cmd_o(cmd_o), .bank_o(bank_o), .row_o(row_o), .col_o(col_o),
    .auto_pre_o(auto_pre_o), .all_bank_o(all_bank_o), .burst_len_o(burst_len_o),
    .mr_sel_o(mr_sel_o), .err_o(err_o), .bank_open_o(bank_open_o),
    .pwr_state_o(pwr_state_o), .odt_en_o(odt_en_o), .mr_flat_o(mr_flat_o)
  );

  int checks = 0, errors = 0;
  bit done = 1'b0;

  // bench model state
  bit [7:0]  m_open = '0;
  bit [1:0]  m_pwr = '0;
  bit [15:0] m_mr [4] = '{default: '0};

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit [2:0] dec(input bit cs, input bit [2:0] code);
    if (cs) return 3'd0;
    case (code)
      3'b011: return 3'd1;
      3'b101: return 3'd2;
      3'b100: return 3'd3;
      3'b010: return 3'd4;
      3'b001: return 3'd5;
      3'b000: return 3'd6;
      default: return 3'd0;
    endcase
  endfunction

  function automatic bit [3:0] burst(input bit [1:0] mode, input bit a12);
    if (mode == 2'b01) return a12 ? 4'd8 : 4'd4;
    if (mode == 2'b10) return 4'd4;
    return 4'd8;
  endfunction

  task automatic step(input bit cke, input bit cs, input bit [2:0] code,
                      input bit [2:0] ba, input bit [15:0] addr, input bit odt);
    bit [2:0] raw, cmd, e_bank;
    bit [15:0] e_row;
    bit [9:0] e_col;
    bit e_ap, e_all, e_err, e_odt;
    bit [3:0] e_bl;
    bit [1:0] e_sel, n_pwr;
    bit [7:0] n_open;
    bit [63:0] e_mr;
    string bl_tag;
    @(negedge clk);
    cke_i = cke; cs_ni = cs; {ras_ni, cas_ni, we_ni} = code;
    ba_i = ba; addr_i = addr; odt_i = odt;
    raw = dec(cs, code);
    cmd = (m_pwr == 2'd0 && cke) ? raw : 3'd0;
    n_pwr = m_pwr;
    if (m_pwr == 2'd0) begin
      if (!cke) n_pwr = (raw == 3'd5 && m_open == 0) ? 2'd3 : (m_open != 0) ? 2'd2 : 2'd1;
    end else if (cke) n_pwr = 2'd0;
    e_bank = 0; e_row = 0; e_col = 0; e_ap = 0; e_all = 0; e_err = 0; e_bl = 0; e_sel = 0;
    n_open = m_open;
    bl_tag = (m_mr[0][1:0] == 2'b01) ? "R6" : "R7";
    e_odt = odt && m_mr[1][2];
    case (cmd)
      3'd1: begin e_bank = ba; e_row = addr; n_open[ba] = 1'b1; end
      3'd2, 3'd3: begin
        e_bank = ba; e_col = addr[9:0]; e_ap = addr[10];
        e_bl = burst(m_mr[0][1:0], addr[12]); e_err = !m_open[ba];
        if (addr[10]) n_open[ba] = 1'b0;
      end
      3'd4: begin
        e_all = addr[10];
        if (addr[10]) n_open = '0; else begin e_bank = ba; n_open[ba] = 1'b0; end
      end
      3'd6: begin
        e_sel = ba[1:0];
        if (!ba[2]) m_mr[ba[1:0]] = addr;
      end
      default: ;
    endcase
    e_mr = {m_mr[3], m_mr[2], m_mr[1], m_mr[0]};
    @(posedge clk); #1;
    chk(cmd_o == cmd, cs ? "R1 cmd" : "R2 cmd", 64'(cmd_o), 64'(cmd));
    chk(bank_o == e_bank && row_o == e_row, "R3 bank/row", {bank_o, row_o}, {e_bank, e_row});
    chk(all_bank_o == e_all && bank_open_o == n_open, "R4 all/open",
        {all_bank_o, bank_open_o}, {e_all, n_open});
    chk(col_o == e_col && auto_pre_o == e_ap, "R5 col/ap", {auto_pre_o, col_o}, {e_ap, e_col});
    chk(burst_len_o == e_bl, bl_tag, 64'(burst_len_o), 64'(e_bl));
    chk(mr_sel_o == e_sel && mr_flat_o == e_mr, "R8 mr", mr_flat_o, e_mr);
    chk(err_o == e_err, "R9 err", 64'(err_o), 64'(e_err));
    chk(pwr_state_o == n_pwr, "R10 pwr", 64'(pwr_state_o), 64'(n_pwr));
    chk(odt_en_o == e_odt, "R11 odt", 64'(odt_en_o), 64'(e_odt));
    m_pwr = n_pwr; m_open = n_open;
  endtask

  localparam bit [2:0] C_ACT = 3'b011, C_RD = 3'b101, C_WR = 3'b100, C_PRE = 3'b010,
                       C_REF = 3'b001, C_MRS = 3'b000, C_NOP = 3'b111;

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    #1;
    chk({cmd_o, bank_open_o, pwr_state_o, err_o, odt_en_o, burst_len_o} == '0 && mr_flat_o == '0,
        "R12 reset", {cmd_o, bank_open_o, pwr_state_o}, 0);
    @(negedge clk); rst_ni = 1'b1;
    // termination enable and gating (R11)
    step(1, 0, C_MRS, 3'd1, 16'h0004, 0);
    step(1, 0, C_NOP, 3'd0, 16'h0000, 1);
    // dropped load with top bank bit set (R8)
    step(1, 0, C_MRS, 3'd5, 16'hFFFF, 0);
    // on-the-fly chop (R6)
    step(1, 0, C_MRS, 3'd0, 16'h0001, 0);
    step(1, 0, C_ACT, 3'd2, 16'hABCD, 0);
    step(1, 0, C_RD,  3'd2, 16'h1055, 0);
    step(1, 0, C_RD,  3'd2, 16'h0055, 0);
    step(1, 0, C_RD,  3'd5, 16'h0001, 0);  // closed bank (R9)
    step(1, 0, C_WR,  3'd2, 16'h0433, 0);  // auto-precharge closes (R5)
    step(1, 0, C_RD,  3'd2, 16'h0000, 0);
    // precharge all vs single (R4)
    step(1, 0, C_ACT, 3'd1, 16'h0011, 0);
    step(1, 0, C_ACT, 3'd3, 16'h0033, 0);
    step(1, 0, C_PRE, 3'd1, 16'h0000, 0);
    step(1, 0, C_PRE, 3'd6, 16'h0400, 0);
    // fixed lengths ignore A12 (R7)
    step(1, 0, C_MRS, 3'd0, 16'h0002, 0);
    step(1, 0, C_RD,  3'd4, 16'h1000, 0);
    step(1, 0, C_MRS, 3'd0, 16'h0000, 0);
    step(1, 0, C_WR,  3'd4, 16'h0000, 0);
    // chip select high masks an activate (R1)
    step(1, 1, C_ACT, 3'd7, 16'h1234, 0);
    // power states (R10)
    step(0, 0, C_NOP, 3'd0, 16'h0000, 0);
    step(0, 0, C_ACT, 3'd0, 16'h0000, 0);
    step(1, 0, C_NOP, 3'd0, 16'h0000, 0);
    step(1, 0, C_ACT, 3'd0, 16'h0100, 0);
    step(0, 0, C_REF, 3'd0, 16'h0000, 0);
    step(1, 0, C_NOP, 3'd0, 16'h0000, 0);
    step(1, 0, C_PRE, 3'd0, 16'h0400, 0);
    step(0, 0, C_REF, 3'd0, 16'h0000, 0);
    step(0, 0, C_NOP, 3'd0, 16'h0000, 1);
    step(1, 0, C_NOP, 3'd0, 16'h0000, 0);
    step(1, 0, C_REF, 3'd0, 16'h0000, 0);
    // termination disabled (R11)
    step(1, 0, C_MRS, 3'd1, 16'h0000, 0);
    step(1, 0, C_NOP, 3'd0, 16'h0000, 1);
    // constrained random mix
    for (int i = 0; i < 4000; i++) begin
      bit cke, cs;
      bit [2:0] ba;
      bit [15:0] addr;
      cke = ($urandom_range(0, 11) != 0);
      cs  = ($urandom_range(0, 5) == 0);
      ba  = 3'($urandom_range(0, 7));
      addr = 16'($urandom);
      step(cke, cs, 3'($urandom_range(0, 7)), ba, addr, 1'($urandom_range(0, 1)));
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule